// File: doc/BRIEF.md
# Supply-Drop Detector Control Logic

This block is the digital control that sits beside an analog supply comparator. The comparator reports, asynchronously, whether the supply has fallen below a programmable threshold. The block chooses that threshold through a 4-bit code that it drives to the analog side. It resynchronises the comparator decision and reports it as a status flag. It then turns a drop into one of two actions, chosen by software: an internal reset request or an interrupt request.

Software programs the block through a small write port with a per-bit write mask, so it can write a whole byte or touch single bits. A combinational read port returns the registers. A settling window runs after each enable. During that window the comparator output is not trusted. The flag reads 0, and neither a reset nor an interrupt can be raised.

Register map, addressed by `wr_addr` / `rd_addr`:
- Address 0 is control. Bit 7 is enable, bit 1 is mode (1 = reset action, 0 = interrupt action), and bit 0 is the flag, which is read-only.
- Address 1 is the threshold code in bits 3..0.
- Address 2 is interrupt control. Bit 0 is the mask (1 = blocked) and bit 1 is pending (write 1 to clear).

Top module: `supply_drop_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x00, address 1 reads 0x00 and address 2 reads 0x01 (mask set, nothing pending), and `rst_req_o`, `irq_o` and `irq_pend_o` are 0.
- R2: Bits 3..0 of address 1 are driven unchanged on `level_o`. Bits 7..4 of address 1 read 0.
- R3: When enable=1, mode=1 and the settling window is over, `rst_req_o` stays high for as long as the synchronised comparator shows the supply below threshold. It is held until the supply recovers and drops within three clock edges after recovery.
- R4: When enable=1, mode=0 and the settling window is over, each fall of the supply below threshold produces exactly one single-cycle pulse on `irq_o` (when unmasked) and sets pending (address 2 bit 1).
- R5: Setting the mode bit while the supply is at or above the threshold produces no reset pulse.
- R6: A full-byte write of 0x00 to address 0 disables the block without any cycle of `rst_req_o`, and address 0 then reads 0x00.
- R7: Clearing the mode bit and then the enable bit with single-bit writes raises no reset. Clearing enable while mode is still set also never raises a reset while the supply is good.
- R8: During the settling window, from enable going 0 to 1 until STAB_CYCLES clocks later, the flag reads 0 and `rst_req_o` and `irq_o` stay 0.
- R9: The mask (address 2 bit 0) blocks `irq_o` but not pending. Writing 1 to bit 1 clears pending. When unmasked and enabled while the supply is already low, an interrupt fires as soon as the settling window ends.
- R10: The flag (address 0 bit 0) equals 1 when the supply is at or above threshold, through a two-flop synchroniser. Writes to bit 0 have no effect.
- R11: A write changes only the bits whose `wr_mask` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write enable |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data (combinational) |
| cmp_below_i | input | 1 | Asynchronous comparator: 1 = supply below threshold |
| level_o | output | 4 | Threshold code to the analog comparator |
| irq_o | output | 1 | Single-cycle interrupt request |
| irq_pend_o | output | 1 | Latched pending interrupt |
| rst_req_o | output | 1 | Internal reset request |

## Verification
A wrong stage count in the synchroniser, or a wrong settling count, shows at the flag bit and at `rst_req_o`. The edge where they change moves by whole cycles, and the bench observes it a few clocks after each comparator step. A stale edge reference or a wrong pending bit shows as an extra or missing `irq_o` pulse, and as a wrong address 2 readback, within one comparator transition. A reset path that ignores mode or settling shows as a forbidden `rst_req_o` cycle during shutdown or arming sequences, which the bench counts over whole windows.

// File: rtl/drop_pkg.sv
package drop_pkg;
    localparam int LVL_W  = 4;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LVL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_IRQ  = 2'd2;

    localparam int B_EN   = 7;
    localparam int B_MODE = 1;
    localparam int B_FLAG = 0;
    localparam int B_MASK = 0;
    localparam int B_PEND = 1;

    typedef struct packed {
        logic             en;
        logic             mode;
        logic [LVL_W-1:0] level;
        logic             mask;
        logic             pend;
        logic             ref_ok;
        logic             irq;
        logic             rst_req;
    } drop_state_t;
endpackage

// File: rtl/drop_sync.sv
module drop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    input  logic rst_val_i,
    output logic q_o
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] stg_q;
    logic [N-1:0] stg_d;

    always_comb begin
        stg_d = {stg_q[N-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {N{rst_val_i}};
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[N-1];
endmodule

// File: rtl/drop_stab_timer.sv
module drop_stab_timer #(
    parameter int STAB_CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic ready_o
);
    localparam int CNT_W = (STAB_CYCLES < 1) ? 1 : $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STAB_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (!en_i)                  cnt_d = LOAD;
        else if (cnt_q != '0)       cnt_d = cnt_q - 1'b1;
        else                        cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/supply_drop_ctrl.sv
module supply_drop_ctrl
    import drop_pkg::*;
#(
    parameter int STAB_CYCLES = 40000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [DATA_W-1:0]    wr_mask,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 cmp_below_i,
    output logic [LVL_W-1:0]     level_o,
    output logic                 irq_o,
    output logic                 irq_pend_o,
    output logic                 rst_req_o
);
    drop_state_t state_q, state_d;

    logic below_s;
    logic ok;
    logic ready;
    logic flag;
    logic fall_evt;

    drop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_i       (cmp_below_i),
        .rst_val_i (1'b0),
        .q_o       (below_s)
    );

    assign ok = ~below_s;

    drop_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (state_q.en),
        .ready_o (ready)
    );

    assign flag     = ready & ok;
    assign fall_evt = ready & ~state_q.mode & state_q.ref_ok & ~ok;

    always_comb begin
        logic wr_ctrl, wr_lvl, wr_irq, pend_clr;
        state_d  = state_q;
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        wr_lvl   = wr_en && (wr_addr == A_LVL);
        wr_irq   = wr_en && (wr_addr == A_IRQ);

        if (wr_ctrl && wr_mask[B_EN])   state_d.en   = wr_data[B_EN];
        if (wr_ctrl && wr_mask[B_MODE]) state_d.mode = wr_data[B_MODE];

        for (int i = 0; i < LVL_W; i++) begin
            if (wr_lvl && wr_mask[i]) state_d.level[i] = wr_data[i];
        end

        if (wr_irq && wr_mask[B_MASK]) state_d.mask = wr_data[B_MASK];
        pend_clr      = wr_irq && wr_mask[B_PEND] && wr_data[B_PEND];
        state_d.pend  = fall_evt | (state_q.pend & ~pend_clr);

        state_d.ref_ok  = ready ? ok : 1'b1;
        state_d.irq     = fall_evt & ~state_q.mask;
        state_d.rst_req = state_q.en & state_q.mode & ready & ~ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.mask    <= 1'b1;
            state_q.ref_ok  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[B_EN]   = state_q.en;
                rd_data[B_MODE] = state_q.mode;
                rd_data[B_FLAG] = flag;
            end
            A_LVL:  rd_data[LVL_W-1:0] = state_q.level;
            A_IRQ: begin
                rd_data[B_MASK] = state_q.mask;
                rd_data[B_PEND] = state_q.pend;
            end
            default: rd_data = '0;
        endcase
    end

    assign level_o    = state_q.level;
    assign irq_o      = state_q.irq;
    assign irq_pend_o = state_q.pend;
    assign rst_req_o  = state_q.rst_req;
endmodule

// File: rtl/supply_drop_ctrl_chk.sv
module supply_drop_ctrl_chk
    import drop_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input drop_state_t st_q,
    input logic        ok,
    input logic        ready,
    input logic        irq_o,
    input logic        irq_pend_o,
    input logic        rst_req_o
);
    assert_rst_needs_reset_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(st_q.en && st_q.mode && ready));

    assert_no_rst_when_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ok |=> !rst_req_o);

    assert_off_no_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> !rst_req_o);

    assert_irq_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_sets_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_pend_o);

    assert_quiet_while_settling_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (!irq_o && !rst_req_o));

    assert_irq_respects_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(!st_q.mask));
endmodule

bind supply_drop_ctrl supply_drop_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_q       (state_q),
    .ok         (ok),
    .ready      (ready),
    .irq_o      (irq_o),
    .irq_pend_o (irq_pend_o),
    .rst_req_o  (rst_req_o)
);

// File: tb/tb_supply_drop_ctrl.sv
`timescale 1ns/1ps
module tb_supply_drop_ctrl;
    localparam int STAB = 20;
    localparam int SETTLE = STAB + 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] wr_mask = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cmp_below = 1'b0;
    logic [3:0] level_o;
    logic       irq_o, irq_pend_o, rst_req_o;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    int rst_cnt = 0;
    logic clr_cnt = 1'b0;

    always #2.5 clk = ~clk;

    supply_drop_ctrl #(.STAB_CYCLES(STAB), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_data), .cmp_below_i(cmp_below), .level_o(level_o),
        .irq_o(irq_o), .irq_pend_o(irq_pend_o), .rst_req_o(rst_req_o)
    );

    always @(posedge clk) begin
        if (clr_cnt) begin
            irq_cnt <= 0;
            rst_cnt <= 0;
        end else begin
            if (irq_o)     irq_cnt <= irq_cnt + 1;
            if (rst_req_o) rst_cnt <= rst_cnt + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, logic [7:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic clear_counts();
        @(negedge clk); clr_cnt = 1'b1;
        @(negedge clk); clr_cnt = 1'b0;
    endtask

    function automatic int falls(logic [5:0] seq);
        int n = 0;
        logic prev = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (!prev && seq[i]) n++;
            prev = seq[i];
        end
        return n;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'h5EED_0042));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 level", v, 8'h00);
        rd(2'd2, v); chk("R1 irqctl", v, 8'h01);
        chk("R1 outputs", {rst_req_o, irq_o, irq_pend_o}, 0);

        // R2 level pass-through, R11 masked write
        wr(2'd1, 8'hFA, 8'hFF);
        chk("R2 level_o", level_o, 4'hA);
        rd(2'd1, v); chk("R2 level read", v, 8'h0A);
        wr(2'd1, 8'h05, 8'h01);
        chk("R11 bit write", level_o, 4'hB);

        // R8 settling then R3 reset mode
        clear_counts();
        cmp_below = 1'b1;
        wr(2'd0, 8'h82, 8'hFF);
        wait_cyc(5);
        chk("R8 no rst while settling", rst_cnt, 0);
        wait_cyc(SETTLE);
        chk("R3 rst while low", rst_req_o, 1);
        cmp_below = 1'b0;
        wait_cyc(4);
        chk("R3 rst released", rst_req_o, 0);
        rd(2'd0, v); chk("R10 flag good", v, 8'h83);
        wr(2'd0, 8'h00, 8'h01);
        rd(2'd0, v); chk("R10 flag write ignored", v, 8'h83);
        cmp_below = 1'b1;
        wait_cyc(4);
        rd(2'd0, v); chk("R10 flag low", v, 8'h82);
        chk("R3 rst again", rst_req_o, 1);
        cmp_below = 1'b0;
        wait_cyc(4);

        // R7 ordered bit-wise shutdown
        clear_counts();
        wr(2'd0, 8'h00, 8'h02);
        wait_cyc(3);
        wr(2'd0, 8'h00, 8'h80);
        wait_cyc(5);
        chk("R7 ordered shutdown no rst", rst_cnt, 0);
        rd(2'd0, v); chk("R7 ctrl off", v, 8'h00);

        // R7 clearing enable with mode still set
        wr(2'd0, 8'h82, 8'hFF);
        wait_cyc(SETTLE);
        clear_counts();
        wr(2'd0, 8'h00, 8'h80);
        wait_cyc(5);
        chk("R7 enable-first no rst", rst_cnt, 0);
        wr(2'd0, 8'h00, 8'hFF);

        // R6 byte shutdown
        wr(2'd0, 8'h82, 8'hFF);
        wait_cyc(SETTLE);
        clear_counts();
        wr(2'd0, 8'h00, 8'hFF);
        wait_cyc(5);
        chk("R6 byte shutdown no rst", rst_cnt, 0);
        rd(2'd0, v); chk("R6 ctrl zero", v, 8'h00);

        // R5 arming while good
        wr(2'd0, 8'h80, 8'hFF);
        wait_cyc(3);
        rd(2'd0, v); chk("R8 flag zero while settling", v, 8'h80);
        wait_cyc(SETTLE);
        clear_counts();
        wr(2'd0, 8'h02, 8'h02);
        wait_cyc(10);
        chk("R5 arm no rst", rst_cnt, 0);
        wr(2'd0, 8'h00, 8'hFF);

        // R4 interrupt mode
        wr(2'd2, 8'h00, 8'h01);
        wr(2'd0, 8'h80, 8'hFF);
        wait_cyc(SETTLE);
        clear_counts();
        cmp_below = 1'b1; wait_cyc(6);
        chk("R4 one pulse", irq_cnt, 1);
        rd(2'd2, v); chk("R4 pending", v, 8'h02);
        cmp_below = 1'b0; wait_cyc(6);
        cmp_below = 1'b1; wait_cyc(6);
        chk("R4 second pulse", irq_cnt, 2);
        chk("R4 no rst in irq mode", rst_cnt, 0);
        wr(2'd2, 8'h02, 8'h02);
        rd(2'd2, v); chk("R9 pending cleared", v, 8'h00);

        // R9 masked
        wr(2'd2, 8'h01, 8'h01);
        clear_counts();
        cmp_below = 1'b0; wait_cyc(6);
        cmp_below = 1'b1; wait_cyc(6);
        chk("R9 masked no pulse", irq_cnt, 0);
        rd(2'd2, v); chk("R9 masked pending", v, 8'h03);
        wr(2'd0, 8'h00, 8'hFF);
        wr(2'd2, 8'h02, 8'hFF);

        // R9 immediate fire after settling
        clear_counts();
        wr(2'd0, 8'h80, 8'hFF);
        wait_cyc(5);
        chk("R8 no irq while settling", irq_cnt, 0);
        wait_cyc(SETTLE);
        chk("R9 immediate irq", irq_cnt, 1);
        wr(2'd0, 8'h00, 8'hFF);
        wr(2'd2, 8'h03, 8'hFF);
        cmp_below = 1'b0;
        wait_cyc(4);

        // random phase
        for (int it = 0; it < 40; it++) begin
            logic       mode = 1'($urandom);
            logic       msk  = 1'($urandom);
            logic [5:0] seq  = 6'($urandom);
            logic [3:0] lvl  = 4'($urandom);
            int exp_irq, exp_pend;
            wr(2'd1, {4'h0, lvl}, 8'hFF);
            wr(2'd2, {7'h0, msk}, 8'h01);
            wr(2'd0, {1'b1, 5'h0, mode, 1'b0}, 8'hFF);
            wait_cyc(SETTLE);
            clear_counts();
            for (int k = 0; k < 6; k++) begin
                cmp_below = seq[k];
                wait_cyc(6);
            end
            exp_irq  = (!mode && !msk) ? falls(seq) : 0;
            exp_pend = (!mode && falls(seq) > 0) ? 1 : 0;
            chk("R4 random irq count", irq_cnt, exp_irq);
            chk("R9 random pending", irq_pend_o, exp_pend);
            chk("R3 random rst", rst_req_o, int'(mode & seq[5]));
            rd(2'd0, v); chk("R10 random flag", v & 1, int'(!seq[5]));
            chk("R2 random level", level_o, lvl);
            wr(2'd0, 8'h00, 8'hFF);
            wr(2'd2, 8'h02, 8'h02);
            cmp_below = 1'b0;
            wait_cyc(4);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule